// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the CPU-facing control plane of a PCI host bridge. It sits on a 32-bit register bus and holds three kinds of state. The first is the bridge's own 64-word configuration header. The second is a set of base registers: an indirect configuration address, a memory base, and an I/O base. The I/O base places a 256 KiB window in CPU address space. The block watches a CPU address input and flags hits in that window, together with the offset into I/O space. It also merges per-device interrupt levels onto four output lines.

Configuration cycles to other devices go through a data-port register. A full-word access to that port starts one configuration transaction on a request/acknowledge master interface, aimed at the address held in the configuration address register. The register bus is stalled with `bus_ready` low until the target acknowledges. Any access to another register completes in the same cycle it is presented.

Bus protocol: the master holds `bus_req` and its qualifiers stable until it sees `bus_ready` high. It samples `bus_rdata` in that cycle and removes or replaces the request in the following cycle.

Top module: `pcib_ctrl`

## Requirements
- R1: An access acts only when `bus_be` is 4'hF and `bus_addr[1:0]` is 0. Any other access completes with `bus_ready` high in its first cycle, reads as zero, changes no register and starts no configuration cycle.
- R2: Byte offsets 0x000 to 0x0FC read and write the 64 header words, word n at offset 4n. The words are held little-endian, so byte offset 4n+0 of a word sits in bits 7:0.
- R3: After reset, the header word at 0x004 reads 0x0290_0080 and every other header word reads zero. The low half is the command word, with only bit 7 set for wait-cycle control. The high half is the status word, with bit 4 (capability list), bit 7 (fast back-to-back) and bits 10:9 = 01 (medium select timing).
- R4: The configuration address register at 0x1C0 resets to zero, stores all 32 written bits and reads them back unchanged.
- R5: The memory base register at 0x1C4 resets to zero, and a write stores the data ANDed with 0xFF00_0001.
- R6: The I/O base register at 0x1C8 resets to 0xFE24_0000. A write whose bits 31:18 differ from the stored bits 31:18 stores the data ANDed with 0xFFFC_0001.
- R7: A write to 0x1C8 whose bits 31:18 equal the stored bits 31:18 is discarded entirely, bit 0 included.
- R8: `io_hit` is high exactly when `cpu_addr[31:18]` equals I/O base bits 31:18. On a hit, `io_offset` equals `cpu_addr[17:0]`; otherwise it is zero. A base write moves the window from the cycle after the write is accepted.
- R9: A full-word read of 0x220 raises `cfg_req` with `cfg_we` low and `cfg_addr` equal to the configuration address register. `cfg_req`, `cfg_we` and `cfg_addr` stay unchanged until `cfg_ack`. `bus_ready` stays low until the cycle after `cfg_ack`, and in that cycle `bus_rdata` carries the `cfg_rdata` captured with the acknowledge.
- R10: A full-word write of 0x220 runs the same handshake with `cfg_we` high and `cfg_wdata` equal to the written data, and raises exactly one configuration request.
- R11: Offsets outside the header, 0x1C0, 0x1C4, 0x1C8 and 0x220 read as zero, and writes to them change nothing.
- R12: `irq_out[k]` is the OR of `dev_irq[d]` over every device number d with d mod 4 equal to k.
- R13: Every acting access other than one to 0x220 completes with `bus_ready` high in the cycle it is first presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Register access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_be | input | 4 | Byte enables; only 4'hF acts |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes in this cycle |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| cfg_ack | input | 1 | Target acknowledges the current request |
| cpu_addr | input | 32 | CPU address to test against the I/O window |
| io_hit | output | 1 | cpu_addr lies in the I/O window |
| io_offset | output | 18 | Offset into I/O space on a hit, else zero |
| dev_irq | input | 32 | Interrupt level per device number |
| irq_out | output | 4 | Merged interrupt lines |

## Verification
A write to the I/O base register and the window decode of `cpu_addr` can fall in the same cycle. In that cycle the decode must still use the old base, and it must switch to the new base at the next edge. The bench sets `cpu_addr` inside the future window, then issues the base write. It samples `io_hit` in the cycle the write is presented and again after the accepting edge, and expects a miss followed by a hit. A second overlap comes from interrupt routing, which stays combinational while a data-port access is stalled. The bench changes `dev_irq` during random traffic and compares the lines against a bench function.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  // Register window layout (byte offsets on the register bus)
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_CFG_ADDR = 12'h1C0;
  localparam logic [REG_AW-1:0] OFS_MEM_BASE = 12'h1C4;
  localparam logic [REG_AW-1:0] OFS_IO_BASE  = 12'h1C8;
  localparam logic [REG_AW-1:0] OFS_DPORT    = 12'h220;

  localparam logic [31:0] MEM_BASE_MASK = 32'hFF00_0001;

  // Header reset contents for the command/status word
  localparam logic [15:0] CMD_RST  = 16'h0080;
  localparam logic [15:0] STAT_RST = 16'h0290;

  typedef enum logic [1:0] {
    DP_IDLE = 2'd0,
    DP_BUSY = 2'd1,
    DP_DONE = 2'd2
  } dport_state_e;

endpackage

// File: rtl/pcib_hdr_store.sv
module pcib_hdr_store #(
  parameter int unsigned WORDS     = 64,
  parameter int unsigned IDX_W     = $clog2(WORDS),
  parameter logic [31:0] WORD1_RST = 32'h0290_0080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);

  logic [31:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [31:0] RST_VAL = (w == 1) ? WORD1_RST : 32'h0;
    logic        load;
    logic [31:0] word_d;
    logic [31:0] word_q;

    assign load = wr_en && (wr_idx == IDX_W'(w));

    always_comb begin
      word_d = word_q;
      if (load) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= RST_VAL;
      else        word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  assign rd_data = words[rd_idx];

endmodule

// File: rtl/pcib_cfg_master.sv
module pcib_cfg_master
  import pcib_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [31:0] start_addr,
  input  logic [31:0] start_wdata,
  output logic        idle,
  output logic        done,
  output logic [31:0] rsp_data,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [31:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_ack
);

  dport_state_e state_q, state_d;
  logic         we_q, we_d;
  logic [31:0]  addr_q, addr_d;
  logic [31:0]  wdata_q, wdata_d;
  logic [31:0]  rdata_q, rdata_d;
  logic         ld_cmd, ld_rsp;

  assign ld_cmd = (state_q == DP_IDLE) && start;
  assign ld_rsp = (state_q == DP_BUSY) && cfg_ack && !we_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DP_IDLE: if (start)   state_d = DP_BUSY;
      DP_BUSY: if (cfg_ack) state_d = DP_DONE;
      DP_DONE:              state_d = DP_IDLE;
      default:              state_d = DP_IDLE;
    endcase
  end

  always_comb begin
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (ld_cmd) begin
      we_d    = start_we;
      addr_d  = start_addr;
      wdata_d = start_wdata;
    end
    if (ld_rsp) rdata_d = cfg_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DP_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign idle      = (state_q == DP_IDLE);
  assign done      = (state_q == DP_DONE);
  assign rsp_data  = rdata_q;
  assign cfg_req   = (state_q == DP_BUSY);
  assign cfg_we    = we_q;
  assign cfg_addr  = addr_q;
  assign cfg_wdata = wdata_q;

endmodule

// File: rtl/pcib_io_window.sv
module pcib_io_window #(
  parameter int unsigned WIN_BITS = 18,
  parameter logic [31:0] BASE_RST = 32'hFE24_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  input  logic [31:0]         cpu_addr,
  output logic [31:0]         base,
  output logic                hit,
  output logic [WIN_BITS-1:0] offset
);

  localparam logic [31:0] BASE_MASK = (32'hFFFF_FFFF << WIN_BITS) | 32'h1;

  logic [31:0] base_q, base_d;
  logic        moves;

  // Only a change of the window position bits makes the write take effect
  assign moves = wr_en && (wr_data[31:WIN_BITS] != base_q[31:WIN_BITS]);

  always_comb begin
    base_d = base_q;
    if (moves) base_d = wr_data & BASE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= BASE_RST;
    else        base_q <= base_d;
  end

  assign base   = base_q;
  assign hit    = (cpu_addr[31:WIN_BITS] == base_q[31:WIN_BITS]);
  assign offset = hit ? cpu_addr[WIN_BITS-1:0] : '0;

endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
  parameter int unsigned NUM_DEV   = 32,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic [NUM_DEV-1:0]   dev_irq,
  output logic [NUM_LINES-1:0] irq_out
);

  function automatic logic [NUM_DEV-1:0] line_mask(input int unsigned line);
    logic [NUM_DEV-1:0] m;
    m = '0;
    for (int unsigned d = 0; d < NUM_DEV; d++) begin
      if ((d % NUM_LINES) == line) m[d] = 1'b1;
    end
    return m;
  endfunction

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [NUM_DEV-1:0] MASK = line_mask(l);
    assign irq_out[l] = |(dev_irq & MASK);
  end

endmodule

// File: rtl/pcib_ctrl.sv
module pcib_ctrl
  import pcib_pkg::*;
#(
  parameter int unsigned NUM_DEV     = 32,
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned IO_WIN_BITS = 18,
  parameter logic [31:0] IO_BASE_RST = 32'hFE24_0000,
  parameter int unsigned HDR_WORDS   = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [11:0]            bus_addr,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_ready,
  output logic                   cfg_req,
  output logic                   cfg_we,
  output logic [31:0]            cfg_addr,
  output logic [31:0]            cfg_wdata,
  input  logic [31:0]            cfg_rdata,
  input  logic                   cfg_ack,
  input  logic [31:0]            cpu_addr,
  output logic                   io_hit,
  output logic [IO_WIN_BITS-1:0] io_offset,
  input  logic [NUM_DEV-1:0]     dev_irq,
  output logic [NUM_LINES-1:0]   irq_out
);

  localparam int unsigned     HDR_IDX_W = $clog2(HDR_WORDS);
  localparam logic [REG_AW-1:0] HDR_END = REG_AW'(HDR_WORDS * 4);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // Address decode
  logic full_word, acting;
  logic sel_hdr, sel_par, sel_mbr, sel_iob, sel_dp;
  logic wr_commit;

  assign full_word = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign acting    = bus_req && full_word;
  assign sel_hdr   = (bus_addr < HDR_END);
  assign sel_par   = (bus_addr == OFS_CFG_ADDR);
  assign sel_mbr   = (bus_addr == OFS_MEM_BASE);
  assign sel_iob   = (bus_addr == OFS_IO_BASE);
  assign sel_dp    = (bus_addr == OFS_DPORT);
  assign wr_commit = acting && bus_we && !sel_dp;

  // Configuration address and memory base registers
  logic [31:0] par_q, par_d;
  logic [31:0] mbr_q, mbr_d;

  always_comb begin
    par_d = par_q;
    mbr_d = mbr_q;
    if (wr_commit && sel_par) par_d = bus_wdata;
    if (wr_commit && sel_mbr) mbr_d = bus_wdata & MEM_BASE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      par_q <= '0;
      mbr_q <= '0;
    end else begin
      par_q <= par_d;
      mbr_q <= mbr_d;
    end
  end

  // Own configuration header
  logic [31:0] hdr_rdata;

  pcib_hdr_store #(
    .WORDS    (HDR_WORDS),
    .IDX_W    (HDR_IDX_W),
    .WORD1_RST({STAT_RST, CMD_RST})
  ) hdr_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_commit && sel_hdr),
    .wr_idx (bus_addr[HDR_IDX_W+1:2]),
    .wr_data(bus_wdata),
    .rd_idx (bus_addr[HDR_IDX_W+1:2]),
    .rd_data(hdr_rdata)
  );

  // I/O window base and decode
  logic [31:0] io_base;

  pcib_io_window #(
    .WIN_BITS(IO_WIN_BITS),
    .BASE_RST(IO_BASE_RST)
  ) iow_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_commit && sel_iob),
    .wr_data (bus_wdata),
    .cpu_addr(cpu_addr),
    .base    (io_base),
    .hit     (io_hit),
    .offset  (io_offset)
  );

  // Data port: indirect configuration cycles
  logic        dp_idle, dp_done;
  logic [31:0] dp_rdata;

  pcib_cfg_master cfgm_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (acting && sel_dp && dp_idle),
    .start_we   (bus_we),
    .start_addr (par_q),
    .start_wdata(bus_wdata),
    .idle       (dp_idle),
    .done       (dp_done),
    .rsp_data   (dp_rdata),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_ack    (cfg_ack)
  );

  // Interrupt routing
  pcib_irq_route #(
    .NUM_DEV  (NUM_DEV),
    .NUM_LINES(NUM_LINES)
  ) irq_i (
    .dev_irq(dev_irq),
    .irq_out(irq_out)
  );

  // Bus response
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sel_hdr)      rd_mux = hdr_rdata;
    else if (sel_par) rd_mux = par_q;
    else if (sel_mbr) rd_mux = mbr_q;
    else if (sel_iob) rd_mux = io_base;
    else if (sel_dp)  rd_mux = dp_rdata;
  end

  assign bus_ready = (acting && sel_dp) ? dp_done : bus_req;
  assign bus_rdata = (acting && bus_ready && !bus_we) ? rd_mux : '0;

endmodule

// File: rtl/pcib_ctrl_chk.sv
module pcib_ctrl_chk #(
  parameter int unsigned NUM_DEV     = 32,
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned IO_WIN_BITS = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [11:0]          bus_addr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic                 bus_ready,
  input logic                 cfg_req,
  input logic                 cfg_we,
  input logic [31:0]          cfg_addr,
  input logic                 cfg_ack,
  input logic [31:0]          io_base,
  input logic [NUM_DEV-1:0]   dev_irq,
  input logic [NUM_LINES-1:0] irq_out
);

  logic full;
  assign full = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);

  assert_partial_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !full) |-> bus_ready);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> cfg_req);

  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> ($stable(cfg_addr) && $stable(cfg_we)));

  assert_dport_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && full && bus_addr == 12'h220 && bus_ready) |-> $past(cfg_ack));

  assert_iob_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && bus_we && full && bus_addr == 12'h1C8 &&
     bus_wdata[31:IO_WIN_BITS] == io_base[31:IO_WIN_BITS]) |=> $stable(io_base));

  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (irq_out == '0));

  assert_irq_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(dev_irq));

endmodule

bind pcib_ctrl pcib_ctrl_chk #(
  .NUM_DEV    (NUM_DEV),
  .NUM_LINES  (NUM_LINES),
  .IO_WIN_BITS(IO_WIN_BITS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_be   (bus_be),
  .bus_wdata(bus_wdata),
  .bus_ready(bus_ready),
  .cfg_req  (cfg_req),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_ack  (cfg_ack),
  .io_base  (io_base),
  .dev_irq  (dev_irq),
  .irq_out  (irq_out)
);

// File: tb/pcib_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcib_ctrl_tb_top;

  localparam int NDEV = 32;
  localparam int NLINE = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        cfg_req, cfg_we, cfg_ack;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic [31:0] cpu_addr;
  logic        io_hit;
  logic [17:0] io_offset;
  logic [NDEV-1:0]  dev_irq;
  logic [NLINE-1:0] irq_out;

  int total = 0;
  int bad   = 0;

  // bench models
  logic [31:0] m_hdr [64];
  logic [31:0] m_par, m_mbr, m_iob;

  // target responder log
  logic [31:0] t_wr_addr, t_wr_data, t_rd_addr;
  int          t_wr_cnt = 0;
  bit          t_busy = 0;
  int          t_dly = 0;

  pcib_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
    .cpu_addr(cpu_addr), .io_hit(io_hit), .io_offset(io_offset),
    .dev_irq(dev_irq), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] resp_data(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_C3A5;
  endfunction

  function automatic logic [NLINE-1:0] exp_irq(input logic [NDEV-1:0] d);
    logic [NLINE-1:0] r;
    r = '0;
    for (int i = 0; i < NDEV; i++) if (d[i]) r[i % NLINE] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] iob_next(input logic [31:0] cur, input logic [31:0] wd);
    if (wd[31:18] != cur[31:18]) return wd & 32'hFFFC_0001;
    return cur;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target responder
  initial begin
    cfg_ack = 1'b0;
    cfg_rdata = '0;
    forever begin
      @(negedge clk);
      if (cfg_ack) cfg_ack = 1'b0;
      else if (cfg_req) begin
        if (!t_busy) begin t_busy = 1; t_dly = $urandom_range(0, 4); end
        if (t_dly == 0) begin
          cfg_ack = 1'b1;
          t_busy = 0;
          if (cfg_we) begin t_wr_addr = cfg_addr; t_wr_data = cfg_wdata; t_wr_cnt++; end
          else begin t_rd_addr = cfg_addr; cfg_rdata = resp_data(cfg_addr); end
        end else t_dly--;
      end
    end
  end

  task automatic bus_xfer(input logic we, input logic [11:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    waits = 0;
    #1;
    while (!bus_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; int w;
    bus_xfer(1'b1, a, 4'hF, d, rd, w);
    if (a != 12'h220) check("R13 write ready wait", w, 0);
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; int w;
    bus_xfer(1'b0, a, 4'hF, 32'h0, rd, w);
    check(req, rd, exp);
  endtask

  task automatic io_chk(input logic [31:0] ca);
    logic hit_e;
    @(negedge clk);
    cpu_addr = ca;
    #1;
    hit_e = (ca[31:18] == m_iob[31:18]);
    check("R8 io_hit", {31'b0, io_hit}, {31'b0, hit_e});
    check("R8 io_offset", {14'b0, io_offset}, hit_e ? {14'b0, ca[17:0]} : 32'h0);
  endtask

  task automatic irq_chk(input logic [NDEV-1:0] d);
    @(negedge clk);
    dev_irq = d;
    #1;
    check("R12 irq_out", {28'b0, irq_out}, {28'b0, exp_irq(d)});
  endtask

  task automatic dport_rd;
    logic [31:0] rd; int w;
    bus_xfer(1'b0, 12'h220, 4'hF, 32'h0, rd, w);
    check("R9 data port read value", rd, resp_data(m_par));
    check("R9 config address used", t_rd_addr, m_par);
    check("R9 stall cycles", {31'b0, (w >= 2)}, 32'h1);
  endtask

  task automatic dport_wr(input logic [31:0] d);
    logic [31:0] rd; int w; int c0;
    c0 = t_wr_cnt;
    bus_xfer(1'b1, 12'h220, 4'hF, d, rd, w);
    check("R10 data port write count", t_wr_cnt - c0, 1);
    check("R10 data port write addr", t_wr_addr, m_par);
    check("R10 data port write data", t_wr_data, d);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, v, nb;
    int w, op, idx;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    cpu_addr = '0; dev_irq = '0;
    for (int i = 0; i < 64; i++) m_hdr[i] = 32'h0;
    m_hdr[1] = 32'h0290_0080;
    m_par = 0; m_mbr = 0; m_iob = 32'hFE24_0000;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state
    rdchk("R3 command/status reset", 12'h004, 32'h0290_0080);
    rdchk("R3 header word 0 reset", 12'h000, 32'h0);
    rdchk("R3 header last word reset", 12'h0FC, 32'h0);
    rdchk("R4 config address reset", 12'h1C0, 32'h0);
    rdchk("R5 memory base reset", 12'h1C4, 32'h0);
    rdchk("R6 io base reset", 12'h1C8, 32'hFE24_0000);
    io_chk(32'hFE24_1234);
    io_chk(32'hFE28_0000);

    // R2 header words, byte 0 in bits 7:0
    wr(12'h0FC, 32'h4433_2211); m_hdr[63] = 32'h4433_2211;
    rdchk("R2 header last word", 12'h0FC, 32'h4433_2211);
    wr(12'h008, 32'hCAFE_F00D); m_hdr[2] = 32'hCAFE_F00D;
    rdchk("R2 header word 2", 12'h008, 32'hCAFE_F00D);

    // R4, R5
    wr(12'h1C0, 32'h8000_0A14); m_par = 32'h8000_0A14;
    rdchk("R4 config address readback", 12'h1C0, 32'h8000_0A14);
    wr(12'h1C4, 32'hFFFF_FFFF); m_mbr = 32'hFF00_0001;
    rdchk("R5 memory base mask", 12'h1C4, 32'hFF00_0001);

    // R7 same upper bits: discarded, bit 0 stays clear
    wr(12'h1C8, 32'hFE27_FFFF);
    rdchk("R7 io base same-window write ignored", 12'h1C8, 32'hFE24_0000);
    // R6 move
    wr(12'h1C8, 32'h1234_5679); m_iob = 32'h1234_0001;
    rdchk("R6 io base masked store", 12'h1C8, 32'h1234_0001);
    io_chk(32'h1237_FFFF);
    io_chk(32'h1234_0000);
    io_chk(32'h1238_0000);
    io_chk(32'h1233_FFFF);

    // concurrency: base write and decode in the same cycle
    @(negedge clk);
    cpu_addr = 32'h4444_0010;
    bus_req = 1; bus_we = 1; bus_addr = 12'h1C8; bus_be = 4'hF; bus_wdata = 32'h4444_0000;
    #1;
    check("R8 decode uses old base during write", {31'b0, io_hit}, 32'h0);
    check("R13 base write ready", {31'b0, bus_ready}, 32'h1);
    @(posedge clk); #1;
    check("R8 decode uses new base after write", {31'b0, io_hit}, 32'h1);
    check("R8 offset after move", {14'b0, io_offset}, 32'h10);
    @(negedge clk); bus_req = 0; bus_we = 0; bus_be = 0;
    m_iob = 32'h4444_0000;

    // R1 partial and misaligned accesses
    bus_xfer(1'b1, 12'h1C0, 4'h3, 32'h1111_1111, rd, w);
    check("R1 partial write ready", w, 0);
    bus_xfer(1'b1, 12'h1C2, 4'hF, 32'h2222_2222, rd, w);
    bus_xfer(1'b0, 12'h1C0, 4'h1, 32'h0, rd, w);
    check("R1 partial read zero", rd, 32'h0);
    rdchk("R1 config address untouched", 12'h1C0, m_par);
    begin
      int c0; c0 = t_wr_cnt;
      bus_xfer(1'b1, 12'h220, 4'h7, 32'h3333_3333, rd, w);
      check("R1 partial data port no cycle", t_wr_cnt - c0, 0);
      check("R1 partial data port ready", w, 0);
    end

    // R11 unassigned
    wr(12'h100, 32'hDEAD_BEEF);
    wr(12'h1CC, 32'hDEAD_BEEF);
    wr(12'h21C, 32'hDEAD_BEEF);
    wr(12'h224, 32'hDEAD_BEEF);
    rdchk("R11 unassigned 0x100", 12'h100, 32'h0);
    rdchk("R11 unassigned 0x1CC", 12'h1CC, 32'h0);
    rdchk("R11 unassigned 0x21C", 12'h21C, 32'h0);
    rdchk("R11 unassigned 0x224", 12'h224, 32'h0);
    rdchk("R11 header word 0 untouched", 12'h000, m_hdr[0]);
    rdchk("R11 io base untouched", 12'h1C8, m_iob);

    // R9, R10 directed
    dport_rd();
    dport_wr(32'h0BAD_C0DE);

    // R12 directed
    irq_chk(32'h0000_0020);
    irq_chk(32'h8000_0000);
    irq_chk(32'h0000_0000);
    irq_chk(32'h1111_1111);

    // random mix
    for (int n = 0; n < 400; n++) begin
      op = $urandom_range(0, 9);
      v = $urandom;
      case (op)
        0: begin idx = $urandom_range(0, 63); wr(12'(idx * 4), v); m_hdr[idx] = v; end
        1: begin idx = $urandom_range(0, 63); rdchk("R2 random header read", 12'(idx * 4), m_hdr[idx]); end
        2: begin wr(12'h1C0, v); m_par = v; rdchk("R4 random config address", 12'h1C0, m_par); end
        3: begin wr(12'h1C4, v); m_mbr = v & 32'hFF00_0001; rdchk("R5 random memory base", 12'h1C4, m_mbr); end
        4: begin
             nb = ($urandom_range(0, 1) == 0) ? {m_iob[31:18], v[17:0]} : v;
             wr(12'h1C8, nb); m_iob = iob_next(m_iob, nb);
             rdchk("R6 R7 random io base", 12'h1C8, m_iob);
           end
        5: dport_rd();
        6: dport_wr(v);
        7: io_chk(($urandom_range(0, 1) == 0) ? {m_iob[31:18], v[17:0]} : v);
        8: irq_chk(v);
        default: begin
          bus_xfer(1'b1, 12'h1C4, 4'(v[3:0] == 4'hF ? 4'h8 : v[3:0]), v, rd, w);
          rdchk("R1 random partial write ignored", 12'h1C4, m_mbr);
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule